// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Transmitter

This block sends asynchronous serial frames from a double-buffered data path. The host writes a byte into a holding register. On a baud tick the byte moves into a shift register, and the block shifts it out on a registered serial line. Each frame carries one extra tag bit after the data. A receiving station uses the tag bit to tell address frames from data frames. The bit takes the place that a parity bit would otherwise hold.

Two flags report progress to the host. The buffer-empty flag shows that the holding register can take a new byte. The done flag shows that the line has run out of work. Each flag drives a level interrupt through its own enable. The bit period is set by an external one-cycle tick strobe. Data length (7 or 8 bits) and the number of stop bits (1 or 2) are selected by two inputs. Those two inputs must be held steady while a frame is on the line.

At the moment the first stop bit begins, the block checks the holding register. If the host has written a new byte, that byte is moved in and the next start bit follows the stop bits directly. If no byte is waiting, the done flag is raised and the line rests at 1.

Top module: `mpx_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `tx_done` is 1, and `irq_empty` and `irq_done` are 0 while their enables are 0.
- R2: A host write (`wr_en` high for one clock) stores `wr_data`. It clears `tx_empty` and `tx_done` at the next clock edge.
- R3: When the block is idle and `tx_empty` is 0, the next clock edge that has `baud_tick` high moves the byte into the shift register. At that same edge `tx_empty` becomes 1 and `txd` becomes 0 (the start bit). `tx_empty` only ever rises on a clock edge that has `baud_tick` high.
- R4: A frame on `txd` is sent in this order: one 0 bit, then the data least significant bit first, then the tag bit, then the stop bits of 1. The data is 8 bits (`wr_data[7:0]`) when `len7`=0 and 7 bits (`wr_data[6:0]`) when `len7`=1. There is one stop bit when `two_stop`=0 and two stop bits when `two_stop`=1.
- R5: `txd` changes only on clock edges where `baud_tick` is high, so each bit lasts exactly one tick period.
- R6: If a byte is waiting when the first stop bit begins, the block moves it in at that edge. The next frame's start bit then follows the last stop bit with no idle bit in between.
- R7: If `tx_empty` is 1 when the first stop bit begins, `tx_done` rises at that same edge while `txd` is 1. After the stop bits, `txd` stays at 1.
- R8: The tag bit value is taken from `mpb_val` when the byte moves into the shift register. Later changes to `mpb_val` do not alter the frame in flight.
- R9: `irq_empty` equals `tx_empty` AND `ie_empty`, and `irq_done` equals `tx_done` AND `ie_done`. Both are levels that fall when their flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| mpb_val | input | 1 | Tag bit value for the next frame |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| ie_done | input | 1 | Enable for the transmission-done interrupt |
| txd | output | 1 | Serial line output, idles at 1 |
| tx_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | Buffer-empty interrupt level |
| irq_done | output | 1 | Transmission-done interrupt level |

## Verification
A wrong shift count or a wrong state step shows up on `txd` within one frame. It appears either as a misplaced tag bit or stop bit, or as an extra or missing bit before the next start bit. A stale pending-load flag makes a second frame appear, or fail to appear, within one or two tick periods after the stop bits. A wrong flag update shows up on `tx_empty`, `tx_done` or the interrupt levels at the very edge where the write, the move into the shift register, or the stop-bit check happens. The sweep therefore compares every logged line bit, and it checks the flags at those edges.

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       mpb_val,
  input  logic       len7,
  input  logic       two_stop,
  input  logic       ie_empty,
  input  logic       ie_done,
  output logic       txd,
  output logic       tx_empty,
  output logic       tx_done,
  output logic       irq_empty,
  output logic       irq_done
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_STOP1, S_STOP2} st_t;

  st_t        st;
  logic [7:0] hold;
  logic [8:0] sh;
  logic [3:0] cnt;
  logic       pend;
  logic       len7_q;

  wire last_bit = (st == S_BITS) && (cnt == 4'd0);
  wire xfer     = baud_tick && !tx_empty && ((st == S_IDLE) || last_bit);
  wire done_set = baud_tick && tx_empty && last_bit;

  assign irq_empty = tx_empty & ie_empty;
  assign irq_done  = tx_done & ie_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hold     <= '0;
      sh       <= '1;
      cnt      <= '0;
      pend     <= 1'b0;
      len7_q   <= 1'b0;
      txd      <= 1'b1;
      tx_empty <= 1'b1;
      tx_done  <= 1'b1;
    end else begin
      if (wr_en) hold <= wr_data;
      tx_empty <= wr_en ? 1'b0 : (xfer ? 1'b1 : tx_empty);
      tx_done  <= wr_en ? 1'b0 : (done_set ? 1'b1 : tx_done);
      if (xfer) begin
        sh     <= len7 ? {1'b1, mpb_val, hold[6:0]} : {mpb_val, hold};
        len7_q <= len7;
      end
      if (baud_tick) begin
        case (st)
          S_IDLE: if (!tx_empty) begin
            txd <= 1'b0;
            st  <= S_START;
          end
          S_START: begin
            txd <= sh[0];
            sh  <= {1'b1, sh[8:1]};
            cnt <= len7_q ? 4'd7 : 4'd8;
            st  <= S_BITS;
          end
          S_BITS: if (cnt == 4'd0) begin
            txd  <= 1'b1;
            pend <= !tx_empty;
            st   <= S_STOP1;
          end else begin
            txd <= sh[0];
            sh  <= {1'b1, sh[8:1]};
            cnt <= cnt - 4'd1;
          end
          S_STOP1: if (two_stop) begin
            st <= S_STOP2;
          end else if (pend) begin
            txd  <= 1'b0;
            pend <= 1'b0;
            st   <= S_START;
          end else begin
            st <= S_IDLE;
          end
          S_STOP2: if (pend) begin
            txd  <= 1'b0;
            pend <= 1'b0;
            st   <= S_START;
          end else begin
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_WR_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!tx_empty && !tx_done)); // R2
  AST_IDLE_XFER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && st == S_IDLE && !tx_empty && !wr_en) |=> (!txd && tx_empty)); // R3
  AST_EMPTY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(baud_tick)); // R3
  AST_TXD_HOLDS_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd)); // R5
  AST_DONE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (txd && tx_empty)); // R7
  AST_IRQ_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> !irq_empty); // R9

endmodule

// File: tb/mpx_uart_tx_bench.sv
module mpx_uart_tx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       mpb_val = 1'b0, len7 = 1'b0, two_stop = 1'b0;
  logic       ie_empty = 1'b0, ie_done = 1'b0;
  logic       txd, tx_empty, tx_done, irq_empty, irq_done;

  mpx_uart_tx u_mpx_uart_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .mpb_val(mpb_val), .len7(len7), .two_stop(two_stop),
    .ie_empty(ie_empty), .ie_done(ie_done), .txd(txd), .tx_empty(tx_empty),
    .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done));

  int errors = 0, checks = 0;
  logic [1:0] tdiv = '0;
  logic lg [0:127];
  int lidx = 0;
  logic ex [0:63];
  int en = 0;

  always @(negedge clk) begin
    if (baud_tick && lidx < 128) begin
      lg[lidx] = txd;
      lidx++;
    end
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_frame(input logic [7:0] d, input logic m);
    ex[en++] = 1'b0;
    for (int i = 0; i < (len7 ? 7 : 8); i++) ex[en++] = d[i];
    ex[en++] = m;
    ex[en++] = 1'b1;
    if (two_stop) ex[en++] = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input logic [7:0] d1, input logic m1, input bit pair,
                     input logic [7:0] d2, input logic m2);
    int f, mism, bad;
    en = 0;
    add_frame(d1, m1);
    if (pair) add_frame(d2, m2);
    @(posedge clk);
    lidx = 0;
    mpb_val = m1;
    wr(d1);
    chk("R2 empty cleared", tx_empty, 0);
    chk("R2 done cleared", tx_done, 0);
    chk("R9 irq_empty low", irq_empty, 0);
    while (!tx_empty) @(negedge clk);
    chk("R3 start bit at transfer", txd, 0);
    chk("R9 irq_empty level", irq_empty, ie_empty);
    if (pair) begin
      mpb_val = m2;
      wr(d2);
      while (!tx_empty) @(negedge clk);
      mpb_val = !m2;
    end else begin
      mpb_val = !m1;
    end
    while (!tx_done) @(negedge clk);
    chk("R7 line high at done", txd, 1);
    chk("R9 irq_done level", irq_done, ie_done);
    repeat (16) @(negedge clk);
    f = -1;
    for (int i = 0; i < lidx; i++)
      if (f < 0 && lg[i] === 1'b0) f = i;
    if (f < 0) f = lidx;
    mism = 0;
    for (int i = 0; i < en; i++)
      if (f + i >= lidx || lg[f + i] !== ex[i]) mism++;
    chk(pair ? "R6 R8 R4 back-to-back frames" : "R4 R5 R8 frame bits", mism, 0);
    bad = 0;
    for (int i = f + en; i < lidx; i++)
      if (lg[i] !== 1'b1) bad++;
    chk("R7 idle mark after frame", bad, 0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 irq_empty", irq_empty, 0);
    chk("R1 irq_done", irq_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ie_empty = 1'b1;
    ie_done = 1'b1;
    @(negedge clk);
    chk("R9 irq_empty with enable", irq_empty, 1);
    chk("R9 irq_done with enable", irq_done, 1);
    for (int c = 0; c < 4; c++) begin
      len7 = c[0];
      two_stop = c[1];
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = 8'hA5 ^ 8'(k * 8'h37) ^ 8'(c * 8'h5A);
        ie_empty = k[0];
        ie_done = k[1];
        run(d, k[0], 1'b0, 8'h00, 1'b0);
        run(~d, k[1], 1'b1, d ^ 8'hFF ^ 8'(k), !k[0]);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule